// File: doc/BRIEF.md
# UART Receive Word Buffer with Fill Trigger

This block is the receive-side storage of a UART. Received words arrive on a push port as 12-bit words: data in bits [7:0], a framing-error flag in bit 8, a parity-error flag in bit 9, a break flag in bit 10 and an overrun flag in bit 11. Words looped back from the transmit path arrive on a second push port. The block holds the words in a circular buffer, drives empty, full and space-available status, and raises a receive-interrupt level when the fill count reaches the trigger level, which is fixed at one word.

A register read pops one entry. The head word is presented combinationally on `pop_word_o`, and its four error bits are latched into a receive-status register on the same edge. A mode input selects buffered operation (16 entries) or holding-register operation (1 entry). Any change of that input flushes the buffer. A break condition received in holding-register mode is stored as a word of its own and also marked in the status register.

Top module: `rx_word_fifo`

## Requirements
- R1: After reset, empty_o=1, full_o=0, space_o=1, rx_irq_o=0 and status_o=0.
- R2: With fifo_mode_i=1 the depth is 16. With fifo_mode_i=0 the depth is 1. space_o is high exactly while the fill count is below the current depth.
- R3: Popped words come out in push order, and indices wrap modulo the current depth. pop_word_o always shows the word at the read position.
- R4: full_o rises when the count reaches the depth. A push while full (with no pop in the same cycle) is dropped: the count and the stored words are unchanged.
- R5: A pop while empty returns the word still held in the slot at the read position, and leaves the count and the read position unchanged.
- R6: rx_irq_o is set when a push makes the count equal 1. It is cleared when a pop leaves the count at 0.
- R7: A push and a pop in the same cycle are both performed. With a non-empty buffer the count is unchanged and the flags follow the final count.
- R8: Any change of fifo_mode_i flushes the buffer: count and read position go to 0, empty_o=1 and full_o=0. rx_irq_o keeps its value.
- R9: While loop_en_i=1, words on rx_valid_i/rx_word_i are ignored and words on lb_valid_i/lb_word_i are stored.
- R10: brk_i with fifo_mode_i=0 stores the word 12'h400 (break flag bit 10 set) and sets status_o[2]. With fifo_mode_i=1, brk_i has no effect.
- R11: Each pop loads status_o with bits [11:8] of the popped word (bit 0 framing, bit 1 parity, bit 2 break, bit 3 overrun). status_clr_i clears status_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode_i | input | 1 | 1 = 16-entry buffer, 0 = single holding entry |
| loop_en_i | input | 1 | Loopback enable, selects the loopback push port |
| rx_valid_i | input | 1 | Received word valid |
| rx_word_i | input | 12 | Received word with error flags |
| lb_valid_i | input | 1 | Loopback word valid |
| lb_word_i | input | 12 | Loopback word |
| brk_i | input | 1 | Break condition received |
| pop_i | input | 1 | Register read that pops one entry |
| status_clr_i | input | 1 | Clear of the receive-status register |
| pop_word_o | output | 12 | Word at the read position |
| status_o | output | 4 | Receive-status error bits |
| empty_o | output | 1 | Buffer empty |
| full_o | output | 1 | Buffer full |
| space_o | output | 1 | At least one free entry |
| rx_irq_o | output | 1 | Receive-interrupt level |

## Verification
The buffer is driven with short bursts carrying distinct error flags, which separates ordering faults from status-latching faults. A full 16-word fill that starts at a non-zero read position, followed by one extra push, shows whether wrap-around and drop-on-full are handled. Pops on an empty buffer, in both depths, show whether the pointer moves when it must not. Simultaneous push and pop, loopback against ignored external words, mode toggles with words pending, and break events in each mode each isolate one control path.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int WORD_W  = 12;
    localparam int ERR_LSB = 8;
    localparam int ERR_W   = WORD_W - ERR_LSB;
    localparam int BRK_IDX = 2;

    typedef logic [WORD_W-1:0] rx_word_t;
    typedef logic [ERR_W-1:0]  rx_err_t;

    localparam rx_word_t BREAK_WORD = rx_word_t'(1) << (ERR_LSB + BRK_IDX);
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_ptr_i,
    input  rx_word_t         wr_word_i,
    input  logic [PTR_W-1:0] rd_ptr_i,
    output rx_word_t         rd_word_o
);
    rx_word_t   mem_d [DEPTH];
    rx_word_t   mem_q [DEPTH];
    logic [DEPTH-1:0] slot_we;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign slot_we[g] = wr_en_i && (wr_ptr_i == PTR_W'(g));
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = slot_we[i] ? wr_word_i : mem_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_word_o = mem_q[rd_ptr_i];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode_i,
    input  logic             push_i,
    input  logic             pop_i,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic             wr_en_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             space_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             empty;
        logic             full;
        logic             irq;
        logic             mode;
    } ctl_t;

    ctl_t             st_d, st_q;
    logic [CNT_W-1:0] depth;
    logic [PTR_W-1:0] mask;
    logic [CNT_W-1:0] cnt_mid;
    logic             flush, pop_eff, push_eff;

    assign depth = st_q.mode ? CNT_W'(DEPTH) : CNT_W'(1);
    assign mask  = st_q.mode ? PTR_W'(DEPTH - 1) : '0;

    always_comb begin
        st_d     = st_q;
        st_d.mode = fifo_mode_i;
        flush    = (fifo_mode_i != st_q.mode);
        pop_eff  = pop_i && (st_q.cnt != '0);
        push_eff = push_i && !flush && ((st_q.cnt != depth) || pop_eff);
        wr_ptr_o = (st_q.rd + st_q.cnt[PTR_W-1:0]) & mask;
        cnt_mid  = st_q.cnt - CNT_W'(pop_eff);
        if (pop_eff) begin
            st_d.rd = (st_q.rd + PTR_W'(1)) & mask;
        end
        if (pop_i && ((cnt_mid + CNT_W'(1)) == CNT_W'(TRIG))) begin
            st_d.irq = 1'b0;
        end
        st_d.cnt = cnt_mid + CNT_W'(push_eff);
        if (push_eff && (st_d.cnt == CNT_W'(TRIG))) begin
            st_d.irq = 1'b1;
        end
        if (flush) begin
            st_d.rd  = '0;
            st_d.cnt = '0;
            st_d.irq = st_q.irq;
        end
        st_d.empty = (st_d.cnt == '0);
        st_d.full  = (st_d.cnt == depth);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rd: '0, cnt: '0, empty: 1'b1, full: 1'b0, irq: 1'b0, mode: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ptr_o = st_q.rd;
    assign wr_en_o  = push_eff;
    assign empty_o  = st_q.empty;
    assign full_o   = st_q.full;
    assign space_o  = (st_q.cnt < depth);
    assign irq_o    = st_q.irq;
endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    pop_i,
    input  rx_err_t pop_err_i,
    input  logic    brk_set_i,
    input  logic    clr_i,
    output rx_err_t status_o
);
    rx_err_t status_d, status_q;

    always_comb begin
        status_d = status_q;
        if (clr_i)     status_d = '0;
        if (pop_i)     status_d = pop_err_i;
        if (brk_set_i) status_d[BRK_IDX] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status_o = status_q;
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode_i,
    input  logic              loop_en_i,
    input  logic              rx_valid_i,
    input  logic [WORD_W-1:0] rx_word_i,
    input  logic              lb_valid_i,
    input  logic [WORD_W-1:0] lb_word_i,
    input  logic              brk_i,
    input  logic              pop_i,
    input  logic              status_clr_i,
    output logic [WORD_W-1:0] pop_word_o,
    output logic [ERR_W-1:0]  status_o,
    output logic              empty_o,
    output logic              full_o,
    output logic              space_o,
    output logic              rx_irq_o
);
    localparam int TRIG_LEVEL = 1;

    logic             push_req, brk_push, wr_en;
    rx_word_t         push_word;
    logic [PTR_W-1:0] rd_ptr, wr_ptr;

    assign brk_push = brk_i && !fifo_mode_i;

    always_comb begin
        if (brk_push) begin
            push_req  = 1'b1;
            push_word = BREAK_WORD;
        end else if (loop_en_i) begin
            push_req  = lb_valid_i;
            push_word = lb_word_i;
        end else begin
            push_req  = rx_valid_i;
            push_word = rx_word_i;
        end
    end

    rxq_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG_LEVEL)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_mode_i (fifo_mode_i),
        .push_i      (push_req),
        .pop_i       (pop_i),
        .rd_ptr_o    (rd_ptr),
        .wr_ptr_o    (wr_ptr),
        .wr_en_o     (wr_en),
        .empty_o     (empty_o),
        .full_o      (full_o),
        .space_o     (space_o),
        .irq_o       (rx_irq_o)
    );

    rxq_store #(.DEPTH(DEPTH)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_ptr_i  (wr_ptr),
        .wr_word_i (push_word),
        .rd_ptr_i  (rd_ptr),
        .rd_word_o (pop_word_o)
    );

    rxq_status i_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_i     (pop_i),
        .pop_err_i (pop_word_o[WORD_W-1:ERR_LSB]),
        .brk_set_i (brk_push),
        .clr_i     (status_clr_i),
        .status_o  (status_o)
    );
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_mode_i,
    input logic       loop_en_i,
    input logic       rx_valid_i,
    input logic       lb_valid_i,
    input logic       brk_i,
    input logic       pop_i,
    input logic       status_clr_i,
    input logic [3:0] status_o,
    input logic       empty_o,
    input logic       full_o,
    input logic       space_o,
    input logic       rx_irq_o
);
    logic mode_prev;
    logic pushing;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_prev <= 1'b0;
        else        mode_prev <= fifo_mode_i;
    end

    assign pushing = (brk_i && !fifo_mode_i) || (loop_en_i ? lb_valid_i : rx_valid_i);

    assert_space_vs_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        space_o != full_o);

    assert_not_full_and_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && pushing && !pop_i && (mode_prev == fifo_mode_i)) |=> full_o);

    assert_empty_pop_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !pushing) |=> empty_o);

    assert_irq_rise_on_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq_o) |-> $fell(empty_o));

    assert_flush_on_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_prev != fifo_mode_i) |=> (empty_o && !full_o));

    assert_status_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr_i && !pop_i && !(brk_i && !fifo_mode_i)) |=> (status_o == 4'h0));
endmodule

bind rx_word_fifo rxq_checker i_rxq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_mode_i  (fifo_mode_i),
    .loop_en_i    (loop_en_i),
    .rx_valid_i   (rx_valid_i),
    .lb_valid_i   (lb_valid_i),
    .brk_i        (brk_i),
    .pop_i        (pop_i),
    .status_clr_i (status_clr_i),
    .status_o     (status_o),
    .empty_o      (empty_o),
    .full_o       (full_o),
    .space_o      (space_o),
    .rx_irq_o     (rx_irq_o)
);

// File: tb/test_rx_word_fifo.sv
`timescale 1ns/1ps
module test_rx_word_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_mode_i = 1'b0;
    logic        loop_en_i = 1'b0;
    logic        rx_valid_i = 1'b0;
    logic [11:0] rx_word_i = '0;
    logic        lb_valid_i = 1'b0;
    logic [11:0] lb_word_i = '0;
    logic        brk_i = 1'b0;
    logic        pop_i = 1'b0;
    logic        status_clr_i = 1'b0;
    logic [11:0] pop_word_o;
    logic [3:0]  status_o;
    logic        empty_o, full_o, space_o, rx_irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [11:0] sb_q[$];
    int          mcnt   = 0;
    int          mdepth = 1;
    bit          mon_stale = 1'b0;
    logic [11:0] stale_exp = '0;

    always #2 clk = ~clk;

    rx_word_fifo i_rx_word_fifo (
        .clk(clk), .rst_n(rst_n), .fifo_mode_i(fifo_mode_i), .loop_en_i(loop_en_i),
        .rx_valid_i(rx_valid_i), .rx_word_i(rx_word_i), .lb_valid_i(lb_valid_i),
        .lb_word_i(lb_word_i), .brk_i(brk_i), .pop_i(pop_i), .status_clr_i(status_clr_i),
        .pop_word_o(pop_word_o), .status_o(status_o), .empty_o(empty_o), .full_o(full_o),
        .space_o(space_o), .rx_irq_o(rx_irq_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Driver: one cycle with optional push (source chosen by loop_en_i) and pop.
    task automatic op(bit ps, logic [11:0] w, bit pp);
        bit pe;
        pe = pp && (mcnt > 0);
        mon_stale = pp && (mcnt == 0);
        if (pp) pop_i = 1'b1;
        if (ps) begin
            if (loop_en_i) begin lb_valid_i = 1'b1; lb_word_i = w; end
            else           begin rx_valid_i = 1'b1; rx_word_i = w; end
        end
        if (pe) mcnt--;
        if (ps && (mcnt < mdepth)) begin
            sb_q.push_back(w);
            mcnt++;
        end
        tick();
        pop_i = 1'b0; rx_valid_i = 1'b0; lb_valid_i = 1'b0;
        mon_stale = 1'b0;
    endtask

    task automatic set_mode(bit m);
        fifo_mode_i = m;
        tick();
        mcnt = 0;
        mdepth = m ? 16 : 1;
        sb_q.delete();
    endtask

    // Monitor: compares each popped word with the scoreboard front.
    always @(negedge clk) begin
        if (rst_n && pop_i) begin
            if (mon_stale) begin
                check("R5 stale word", pop_word_o, stale_exp);
            end else if (sb_q.size() == 0) begin
                check("R3 unexpected pop", 32'h1, 32'h0);
            end else begin
                check("R3 pop order", pop_word_o, sb_q.pop_front());
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 empty", empty_o, 1); check("R1 full", full_o, 0);
        check("R1 space", space_o, 1); check("R1 irq", rx_irq_o, 0);
        check("R1 status", status_o, 0);

        set_mode(1'b1);
        check("R8 empty after mode change", empty_o, 1);

        // R3/R6/R11 short burst with distinct error flags
        op(1, 12'h141, 0);
        check("R6 irq on first word", rx_irq_o, 1);
        check("R2 space", space_o, 1);
        op(1, 12'h242, 0);
        op(1, 12'h843, 0);
        op(0, '0, 1); check("R11 framing bit", status_o, 4'h1);
        op(0, '0, 1); check("R11 parity bit", status_o, 4'h2);
        check("R6 irq held while words remain", rx_irq_o, 1);
        op(0, '0, 1); check("R11 overrun bit", status_o, 4'h8);
        check("R6 irq cleared on last pop", rx_irq_o, 0);
        check("R3 empty after drain", empty_o, 1);

        // R4 fill to 16 from read position 3, then one extra push
        for (int i = 0; i < 16; i++) begin
            op(1, 12'h0A0 + 12'(i), 0);
            if (i == 14) check("R4 not full at 15", full_o, 0);
        end
        check("R4 full at 16", full_o, 1);
        check("R2 no space at 16", space_o, 0);
        op(1, 12'hFFF, 0);
        check("R4 still full after dropped push", full_o, 1);
        for (int i = 0; i < 16; i++) op(0, '0, 1);
        check("R3 empty after wrap drain", empty_o, 1);

        // R5 pop while empty returns the slot at the read position (word 0 of the fill)
        stale_exp = 12'h0A0;
        op(0, '0, 1);
        check("R5 still empty", empty_o, 1);
        check("R5 space kept", space_o, 1);
        op(1, 12'h0B1, 0);
        op(0, '0, 1);
        check("R5 pointer unmoved", empty_o, 1);

        // R7 simultaneous push and pop
        op(1, 12'h0C1, 0);
        op(1, 12'h0C2, 0);
        op(1, 12'h0C3, 1);
        check("R7 not empty", empty_o, 0);
        op(0, '0, 1);
        check("R7 one left", empty_o, 0);
        op(0, '0, 1);
        check("R7 empty at end", empty_o, 1);

        // R9 loopback: external word ignored, loopback word stored
        loop_en_i = 1'b1;
        rx_valid_i = 1'b1; rx_word_i = 12'h0EE;
        tick();
        rx_valid_i = 1'b0;
        check("R9 external word ignored", empty_o, 1);
        op(1, 12'h055, 0);
        check("R9 loopback word stored", empty_o, 0);
        op(0, '0, 1);
        loop_en_i = 1'b0;
        check("R9 drained", empty_o, 1);

        // R8 flush with words pending; irq keeps its value
        op(1, 12'h011, 0);
        op(1, 12'h022, 0);
        check("R8 irq before toggle", rx_irq_o, 1);
        set_mode(1'b0);
        check("R8 flush empty", empty_o, 1);
        check("R8 flush full", full_o, 0);
        check("R8 irq kept", rx_irq_o, 1);

        // R2 single-entry mode
        op(1, 12'h033, 0);
        check("R2 full at depth 1", full_o, 1);
        check("R2 no space at depth 1", space_o, 0);
        op(1, 12'h044, 0);
        check("R4 drop in single mode", full_o, 1);
        op(0, '0, 1);
        check("R6 irq cleared single", rx_irq_o, 0);
        stale_exp = 12'h033;
        op(0, '0, 1);
        check("R5 empty after stale pop", empty_o, 1);

        // R10 break in single-entry mode
        brk_i = 1'b1;
        sb_q.push_back(12'h400); mcnt++;
        tick();
        brk_i = 1'b0;
        check("R10 break stored", empty_o, 0);
        check("R10 break status", status_o, 4'h4);
        op(0, '0, 1);
        check("R11 status from break word", status_o, 4'h4);
        status_clr_i = 1'b1;
        tick();
        status_clr_i = 1'b0;
        check("R11 status cleared", status_o, 4'h0);

        // R10 break ignored in buffered mode
        set_mode(1'b1);
        brk_i = 1'b1;
        tick();
        brk_i = 1'b0;
        check("R10 break ignored empty", empty_o, 1);
        check("R10 break ignored status", status_o, 4'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule